// File: doc/BRIEF.md
# Aligned transfer command segmenter

This block accepts one block-transfer request at a time, made of a start address, a byte count and a direction flag. It splits the request into a series of segments. Every segment starts on an address aligned to its own size. The rule is greedy and aims to keep the segment count low. It uses a 2-byte access whenever the address sits two bytes off an 8-byte or 4-byte boundary, a 4-byte access to reach an 8-byte boundary or to finish a short tail, and an 8-byte-multiple burst everywhere else. Each segment is offered to a downstream frame engine over a valid/ready handshake, together with its command code, address, length and running byte offset.

A request whose start address is odd is refused, and so is a read of an odd number of bytes. In both cases an error flag is raised and no segment is produced. A write of an odd number of bytes is lengthened by one byte. The segment that carries that extra byte is marked so the data path can put a zero into it. A single-cycle completion pulse follows the acceptance of the final segment.

Top module: `xfer_segmenter`

## Requirements
- R1: When the current address modulo 8 is 2 or 6, or exactly 2 bytes remain, the segment is a 2-byte access: length 2, command code 0 for a read and 1 for a write.
- R2: Otherwise, when the address modulo 8 is 4 or at most 6 bytes remain, the segment is a 4-byte access: length 4, command code 2 for a read and 3 for a write.
- R3: Otherwise the segment is a burst, with command code 4 for a read and 5 for a write. Its length is the remaining count rounded down to a multiple of 8, limited to BURST_MAX (default 240).
- R4: Bit 0 of the command code equals the request's write flag. The write code is always the read code plus one.
- R5: The first segment carries the start address and offset 0. Each later segment's address and offset equal the previous values plus the previous segment length. The request ends when the remaining count reaches zero.
- R6: A request with an odd start address is accepted but raises err, produces no segment and no done pulse.
- R7: A read request with an odd length is treated in the same way as R6.
- R8: A write with an odd length is extended by one byte. The segment containing the final padded byte asserts seg_pad, and no other segment does.
- R9: done is high for exactly the one cycle after the final segment is accepted. A zero-length request raises done in the cycle after its acceptance and produces no segment.
- R10: err is updated on every accepted request. It is set for a rejected request, cleared for a valid one, and holds its value until the next request is accepted.
- R11: While seg_valid is high and seg_ready is low, seg_valid, seg_cmd, seg_addr, seg_len and seg_offset stay unchanged.
- R12: req_ready is high exactly when no segment is pending. A new request may be accepted in the same cycle that done is high.
- R13: Reading 260 bytes from an address ending in 0x02 produces lengths 2, 4, 240, 8, 4, 2 at addresses ending 0x002, 0x004, 0x008, 0x0F8, 0x100, 0x104.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Frame engine takes the segment |
| seg_cmd | output | 3 | Command code {kind, write} |
| seg_addr | output | AW | Segment start address |
| seg_len | output | SLW | Segment length in bytes |
| seg_offset | output | LW+1 | Byte offset of segment in request |
| seg_pad | output | 1 | Segment ends in the zero pad byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |

## Verification
The completion pulse of one request and the acceptance of the next can happen in the same cycle. This is because the block returns to idle on the same edge that takes the last segment. The bench drives the next request in the very cycle where it expects done. It therefore checks, on every request of the sweep, that done and req_ready are both high and that the new request is taken on the following edge. When the previous request was a rejected one, the same overlap also tests err: err must clear on the edge that accepts a valid request.

// File: rtl/xseg_pkg.sv
`timescale 1ns/1ps
package xseg_pkg;

   // Upper two bits of the command code; bit 0 carries the direction.
   typedef enum logic [1:0] {
      KIND_HALF  = 2'd0,
      KIND_WORD  = 2'd1,
      KIND_BURST = 2'd2
   } seg_kind_e;

endpackage

// File: rtl/xseg_req_check.sv
`timescale 1ns/1ps
module xseg_req_check #(
   parameter int LW = 16,
   parameter int RW = LW + 1
) (
   input  logic          addr_lsb,
   input  logic [LW-1:0] len,
   input  logic          write,
   output logic          bad,
   output logic          pad,
   output logic [RW-1:0] padded
);

   // Reads need an even count, every request an even start address.
   assign bad    = addr_lsb | (~write & len[0]);
   assign pad    = write & len[0];
   assign padded = RW'(len) + RW'(pad);

endmodule

// File: rtl/xseg_select.sv
`timescale 1ns/1ps
module xseg_select
   import xseg_pkg::*;
#(
   parameter int RW        = 17,
   parameter int SLW       = 8,
   parameter int BURST_MAX = 240
) (
   input  logic [2:0]     align,
   input  logic [RW-1:0]  remain,
   output seg_kind_e      kind,
   output logic [SLW-1:0] len
);

   localparam logic [RW-1:0] CAP = RW'(BURST_MAX);

   logic [RW-1:0] rem_oct;
   assign rem_oct = {remain[RW-1:3], 3'b000};

   always_comb begin
      if (align == 3'd2 || align == 3'd6 || remain == RW'(2)) begin
         kind = KIND_HALF;
         len  = SLW'(2);
      end else if (align == 3'd4 || remain <= RW'(6)) begin
         kind = KIND_WORD;
         len  = SLW'(4);
      end else begin
         kind = KIND_BURST;
         len  = (rem_oct > CAP) ? SLW'(BURST_MAX) : rem_oct[SLW-1:0];
      end
   end

endmodule

// File: rtl/xseg_ctrl.sv
`timescale 1ns/1ps
module xseg_ctrl #(
   parameter int AW  = 32,
   parameter int RW  = 17,
   parameter int SLW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [AW-1:0]  req_addr,
   input  logic           req_write,
   input  logic           bad,
   input  logic           pad,
   input  logic [RW-1:0]  padded,
   input  logic           seg_ready,
   input  logic [SLW-1:0] seg_len,
   output logic           req_ready,
   output logic           seg_valid,
   output logic [AW-1:0]  seg_addr,
   output logic [RW-1:0]  seg_offset,
   output logic [RW-1:0]  seg_rem,
   output logic           seg_wr,
   output logic           seg_pad,
   output logic           done,
   output logic           err
);

   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;

   state_e        state_q;
   logic [AW-1:0] addr_q;
   logic [RW-1:0] rem_q;
   logic [RW-1:0] off_q;
   logic          wr_q;
   logic          pad_q;
   logic          done_q;
   logic          err_q;

   logic accept;
   logic fire;
   logic last_seg;

   assign req_ready = (state_q == ST_IDLE);
   assign seg_valid = (state_q == ST_RUN);
   assign accept    = req_valid & req_ready;
   assign fire      = seg_valid & seg_ready;
   assign last_seg  = (rem_q == RW'(seg_len));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         off_q   <= '0;
         wr_q    <= 1'b0;
         pad_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            err_q <= bad;
            if (!bad) begin
               addr_q <= req_addr;
               rem_q  <= padded;
               off_q  <= '0;
               wr_q   <= req_write;
               pad_q  <= pad;
               if (padded == '0) begin
                  done_q <= 1'b1;
               end else begin
                  state_q <= ST_RUN;
               end
            end
         end
         if (fire) begin
            addr_q <= addr_q + AW'(seg_len);
            rem_q  <= rem_q - RW'(seg_len);
            off_q  <= off_q + RW'(seg_len);
            if (last_seg) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
         end
      end
   end

   assign seg_addr   = addr_q;
   assign seg_offset = off_q;
   assign seg_rem    = rem_q;
   assign seg_wr     = wr_q;
   assign seg_pad    = seg_valid & pad_q & last_seg;
   assign done       = done_q;
   assign err        = err_q;

endmodule

// File: rtl/xfer_segmenter.sv
`timescale 1ns/1ps
module xfer_segmenter
   import xseg_pkg::*;
#(
   parameter  int AW        = 32,
   parameter  int LW        = 16,
   parameter  int BURST_MAX = 240,
   localparam int RW        = LW + 1,
   localparam int SLW       = $clog2(BURST_MAX + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [AW-1:0]  req_addr,
   input  logic [LW-1:0]  req_len,
   input  logic           req_write,
   output logic           seg_valid,
   input  logic           seg_ready,
   output logic [2:0]     seg_cmd,
   output logic [AW-1:0]  seg_addr,
   output logic [SLW-1:0] seg_len,
   output logic [RW-1:0]  seg_offset,
   output logic           seg_pad,
   output logic           done,
   output logic           err
);

   generate
      if (BURST_MAX < 8 || (BURST_MAX % 8) != 0) begin : g_bad_burst
         $error("BURST_MAX must be a nonzero multiple of 8");
      end
      if (RW < SLW || LW < 3) begin : g_bad_len
         $error("LW too narrow for BURST_MAX");
      end
      if (AW < 3) begin : g_bad_addr
         $error("AW must be at least 3");
      end
   endgenerate

   logic          bad;
   logic          pad;
   logic [RW-1:0] padded;
   logic [RW-1:0] rem;
   logic          wr;
   seg_kind_e     kind;

   xseg_req_check #(.LW(LW), .RW(RW)) u_check (
      .addr_lsb (req_addr[0]),
      .len      (req_len),
      .write    (req_write),
      .bad      (bad),
      .pad      (pad),
      .padded   (padded)
   );

   xseg_ctrl #(.AW(AW), .RW(RW), .SLW(SLW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .bad        (bad),
      .pad        (pad),
      .padded     (padded),
      .seg_ready  (seg_ready),
      .seg_len    (seg_len),
      .req_ready  (req_ready),
      .seg_valid  (seg_valid),
      .seg_addr   (seg_addr),
      .seg_offset (seg_offset),
      .seg_rem    (rem),
      .seg_wr     (wr),
      .seg_pad    (seg_pad),
      .done       (done),
      .err        (err)
   );

   xseg_select #(.RW(RW), .SLW(SLW), .BURST_MAX(BURST_MAX)) u_select (
      .align  (seg_addr[2:0]),
      .remain (rem),
      .kind   (kind),
      .len    (seg_len)
   );

   assign seg_cmd = {kind, wr};

endmodule

// File: rtl/xseg_checker.sv
`timescale 1ns/1ps
module xseg_checker #(
   parameter int AW        = 32,
   parameter int RW        = 17,
   parameter int SLW       = 8,
   parameter int BURST_MAX = 240
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_ready,
   input logic           seg_valid,
   input logic           seg_ready,
   input logic [1:0]     seg_kind,
   input logic [AW-1:0]  seg_addr,
   input logic [SLW-1:0] seg_len,
   input logic [RW-1:0]  seg_offset,
   input logic           done,
   input logic           err
);

   assert_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_kind == 2'd0) |-> (seg_len == SLW'(2) && seg_addr[0] == 1'b0));

   assert_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_kind == 2'd1) |-> (seg_len == SLW'(4) && seg_addr[1:0] == 2'b00));

   assert_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_kind == 2'd2) |-> (seg_addr[2:0] == 3'b000 && seg_len[2:0] == 3'b000
                                          && seg_len != '0 && seg_len <= SLW'(BURST_MAX)));

   assert_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_kind != 2'd3));

   assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_ready) |=> (done || (seg_valid
         && seg_addr == $past(seg_addr) + AW'($past(seg_len))
         && seg_offset == $past(seg_offset) + RW'($past(seg_len)))));

   assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!seg_valid && !done));

   assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!seg_valid && req_ready));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done || !$past(seg_valid));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)
                                    && $stable(seg_kind) && $stable(seg_offset)));

   assert_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, seg_valid}) && (req_ready || seg_valid));

endmodule

bind xfer_segmenter xseg_checker #(
   .AW(AW), .RW(RW), .SLW(SLW), .BURST_MAX(BURST_MAX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .seg_valid  (seg_valid),
   .seg_ready  (seg_ready),
   .seg_kind   (seg_cmd[2:1]),
   .seg_addr   (seg_addr),
   .seg_len    (seg_len),
   .seg_offset (seg_offset),
   .done       (done),
   .err        (err)
);

// File: tb/xfer_segmenter_tb.sv
`timescale 1ns/1ps
module xfer_segmenter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        req_write = 1'b0;
   logic        seg_valid;
   logic        seg_ready = 1'b0;
   logic [2:0]  seg_cmd;
   logic [31:0] seg_addr;
   logic [7:0]  seg_len;
   logic [16:0] seg_offset;
   logic        seg_pad;
   logic        done;
   logic        err;

   int checks = 0;
   int errors = 0;
   int stall_ctr = 0;

   always #10 clk = ~clk;

   xfer_segmenter #(.AW(32), .LW(16), .BURST_MAX(240)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_cmd(seg_cmd),
      .seg_addr(seg_addr), .seg_len(seg_len), .seg_offset(seg_offset),
      .seg_pad(seg_pad), .done(done), .err(err)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Selection rule from the requirements: returns kind and length.
   function automatic void pick(input int align, input int rem, output int kind, output int ln);
      if (align == 2 || align == 6 || rem == 2) begin
         kind = 0; ln = 2;
      end else if (align == 4 || rem <= 6) begin
         kind = 1; ln = 4;
      end else begin
         kind = 2; ln = (rem / 8) * 8;
         if (ln > 240) ln = 240;
      end
   endfunction

   // Called just after a negedge; returns just after the negedge where done is judged.
   task automatic run_req(input logic [31:0] a, input int l, input bit w);
      bit bad;
      int rem, off, kind, ln;
      logic [31:0] cur;
      req_valid = 1'b1; req_addr = a; req_len = l[15:0]; req_write = w;
      #1;
      chk("R12 req_ready with request pending", req_ready, 1);
      @(negedge clk); #1;
      req_valid = 1'b0;
      bad = a[0] || (!w && l[0]);
      if (bad) begin
         chk(a[0] ? "R6 err on odd address" : "R7 err on odd read length", err, 1);
         chk("R6 no segment after reject", seg_valid, 0);
         chk("R7 no done after reject", done, 0);
         @(negedge clk); #1;
         chk("R10 err holds", err, 1);
         chk("R6 still no segment", seg_valid, 0);
         return;
      end
      chk("R10 err cleared on valid request", err, 0);
      rem = l + ((w && l[0]) ? 1 : 0);
      cur = a; off = 0;
      if (rem == 0) begin
         chk("R9 zero length done", done, 1);
         chk("R9 zero length no segment", seg_valid, 0);
         return;
      end
      while (rem > 0) begin
         pick(int'(cur[2:0]), rem, kind, ln);
         chk("R5 seg_valid while remaining", seg_valid, 1);
         chk(kind == 0 ? "R1 command code" : (kind == 1 ? "R2 command code" : "R3 command code"),
             seg_cmd, kind * 2 + (w ? 1 : 0));
         chk(kind == 0 ? "R1 length" : (kind == 1 ? "R2 length" : "R3 length"), seg_len, ln);
         chk("R4 direction bit", seg_cmd[0], w);
         chk("R5 address", seg_addr, cur);
         chk("R5 offset", seg_offset, off);
         chk("R8 pad marker", seg_pad, (w && l[0] && rem == ln) ? 1 : 0);
         chk("R9 no done mid request", done, 0);
         stall_ctr++;
         if (stall_ctr % 5 == 2) begin
            seg_ready = 1'b0;
            @(negedge clk); #1;
            continue;   // R11: same values re-checked next pass
         end
         seg_ready = 1'b1;
         @(negedge clk); #1;
         seg_ready = 1'b0;
         cur = cur + ln; off = off + ln; rem = rem - ln;
      end
      chk("R9 done after last segment", done, 1);
      chk("R9 no segment with done", seg_valid, 0);
      chk("R12 ready in done cycle", req_ready, 1);
   endtask

   initial begin
      #3_800_000;
      checks++; errors++;
      $display("FAIL R9 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int exp_len[6]  = '{2, 4, 240, 8, 4, 2};
      int exp_lo[6]   = '{'h002, 'h004, 'h008, 'h0F8, 'h100, 'h104};
      int exp_cmd[6]  = '{0, 2, 4, 4, 2, 0};
      repeat (3) @(negedge clk);
      #1;
      chk("R12 reset ready", req_ready, 1);
      chk("R12 reset seg_valid", seg_valid, 0);
      chk("R9 reset done", done, 0);
      chk("R10 reset err", err, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R13 worked example, seg_ready held high.
      req_valid = 1'b1; req_addr = 32'h6003_0002; req_len = 16'd260; req_write = 1'b0;
      @(negedge clk); #1;
      req_valid = 1'b0;
      seg_ready = 1'b1;
      for (int i = 0; i < 6; i++) begin
         chk("R13 length", seg_len, exp_len[i]);
         chk("R13 address", seg_addr, 32'h6003_0000 + exp_lo[i]);
         chk("R13 command", seg_cmd, exp_cmd[i]);
         @(negedge clk); #1;
      end
      seg_ready = 1'b0;
      chk("R13 done", done, 1);

      // Sweep: start address low bits x lengths x direction, back to back.
      for (int lo = 0; lo < 16; lo++) begin
         for (int l = 0; l < 116; l++) begin
            for (int w = 0; w < 2; w++) begin
               run_req(32'h1000_0000 + lo, (l < 100) ? l : l + 136, w[0]);
            end
         end
      end
      run_req(32'h2000_0006, 1001, 1'b1);
      run_req(32'h2000_0000, 1000, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule